// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a segment-relative offset onto a flat linear address. Each request gives the processor's addressing mode, which segment register is in use, that register's cached descriptor state and the offset. The unit returns the linear address together with a two-bit result code. The arithmetic depends on the mode. Real and virtual-8086 modes add a 16-bit offset to a 20-bit style base. Protected and compatibility modes add 32-bit values with wrap-around. 64-bit mode treats most segments as flat and only FS and GS contribute a base.

Protected and 64-bit modes also check the cached attributes. A segment that is not present is rejected first. A descriptor that is not a code or data descriptor is rejected next. For ordinary segments outside 64-bit mode, the offset is then checked against the limit. Expand-down data segments use the opposite limit test. The translation path is combinational. One register stage follows it, and a one-cycle valid pulse marks each result. Privilege checks, descriptor fetch and paging are handled elsewhere.

Top module: `seg_xlat_unit`

## Requirements
- R1: `rsp_valid` rises exactly one clock after each cycle in which `req_valid` is high and is low in every other cycle. Reset drives `rsp_valid` low.
- R2: In a cycle without a request, `rsp_addr` and `rsp_status` keep the values of the last response.
- R3: Mode codes are 0 real, 1 virtual-8086, 2 protected/compatibility and 3 64-bit. In modes 0 and 1, the address is the low 16 offset bits plus either `seg_base[31:0]` (when `seg_hid_ok` is 1) or `seg_sel` shifted left by four (when it is 0). The sum wraps at 32 bits and is zero-extended. The status is always 0 (success), whatever the present bit, type or limit.
- R4: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS and 5 GS. In mode 3, a segment code other than 4 or 5 gives an address equal to the full offset. Codes 4 and 5 give the 64-bit sum of base and offset, wrapping at 64 bits.
- R5: In mode 3, no limit test is made, so a present code or data segment always succeeds.
- R6: In mode 2, the address is `seg_base[31:0] + req_offset[31:0]` modulo 2^32, zero-extended. The upper offset bits are ignored.
- R7: Status codes are 0 success, 1 out of bounds, 2 invalid type and 3 not present. In modes 2 and 3, `seg_present` = 0 gives status 3.
- R8: In modes 2 and 3, a present segment whose `seg_dtype` is 0 (a system descriptor rather than code or data) gives status 2.
- R9: Type bit 3 set marks a code segment. Bit 3 clear with bit 2 clear marks a normal data segment. For these types in mode 2, `req_offset[31:0]` greater than `seg_limit` gives status 1. An offset equal to the limit succeeds.
- R10: Type bit 3 clear with bit 2 set marks an expand-down data segment. For these types in mode 2, an offset less than or equal to `seg_limit` gives status 1. With `seg_gran` = 0, an offset above 0xFFFF also gives status 1.
- R11: Whenever the status is not 0, `rsp_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per translation |
| req_mode | input | 2 | Addressing mode code |
| req_seg | input | 3 | Segment register code |
| seg_sel | input | 16 | Cached selector value |
| seg_base | input | 64 | Cached segment base |
| seg_limit | input | 32 | Cached byte-granular limit |
| seg_present | input | 1 | Present attribute |
| seg_dtype | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| seg_type | input | 4 | Descriptor type field |
| seg_gran | input | 1 | Granularity attribute |
| seg_hid_ok | input | 1 | Cached base is valid |
| req_offset | input | 64 | Offset within the segment |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_addr | output | 64 | Linear address |
| rsp_status | output | 2 | Result code |

## Verification
The hardest region to reach is the edge of the expand-down test. There, two separate conditions (the inverted limit compare and the 64 KiB ceiling that applies when granularity is clear) must each be made to fail and to pass on their own. The stimulus places offsets exactly at the limit, one above it, and just past 0xFFFF with the granularity bit both clear and set. The wrap points are also driven on purpose: real-mode sums that overflow 32 bits, 64-bit FS/GS sums that overflow 64 bits, and protected-mode offsets whose upper half is non-zero. Together these show that each path truncates at its own width.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  localparam int LEG_W  = 32;  // width of legacy linear addresses
  localparam int REAL_W = 16;  // offset bits used in real/v86 mode

  localparam logic [1:0] XM_REAL   = 2'd0;
  localparam logic [1:0] XM_V86    = 2'd1;
  localparam logic [1:0] XM_PROT   = 2'd2;
  localparam logic [1:0] XM_LONG64 = 2'd3;

  localparam logic [2:0] SR_FS = 3'd4;
  localparam logic [2:0] SR_GS = 3'd5;

  typedef enum logic [1:0] {
    XS_OK      = 2'd0,
    XS_BOUNDS  = 2'd1,
    XS_BADTYPE = 2'd2,
    XS_ABSENT  = 2'd3
  } xlat_status_e;

  // real / v86 sum: 16-bit offset onto a cached base or a paragraph number
  function automatic logic [LEG_W-1:0] legacy_sum(
    input logic [REAL_W-1:0] off16,
    input logic [LEG_W-1:0]  base32,
    input logic [15:0]       sel,
    input logic              hid_ok
  );
    logic [LEG_W-1:0] origin;
    origin = hid_ok ? base32 : {12'd0, sel, 4'd0};
    return origin + {16'd0, off16};
  endfunction

  // protected / compatibility sum, wrapping at 32 bits
  function automatic logic [LEG_W-1:0] compat_sum(
    input logic [LEG_W-1:0] base32,
    input logic [LEG_W-1:0] off32
  );
    return base32 + off32;
  endfunction

  // a segment register that carries a base in 64-bit mode
  function automatic logic keeps_base64(input logic [2:0] seg);
    return (seg == SR_FS) || (seg == SR_GS);
  endfunction

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 16
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        seg,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] base,
  input  logic              hid_ok,
  input  logic [ADDR_W-1:0] offset,
  output logic              path_legacy,
  output logic              path_flat64,
  output logic [ADDR_W-1:0] flat_addr
);

  logic [LEG_W-1:0] leg_addr;
  logic [LEG_W-1:0] cmp_addr;
  logic [15:0]      sel16;

  assign sel16       = 16'(sel);
  assign path_legacy = (mode == XM_REAL) || (mode == XM_V86);
  assign path_flat64 = (mode == XM_LONG64);
  assign leg_addr    = legacy_sum(offset[REAL_W-1:0], base[LEG_W-1:0], sel16, hid_ok);
  assign cmp_addr    = compat_sum(base[LEG_W-1:0], offset[LEG_W-1:0]);

  always_comb begin
    if (path_legacy)
      flat_addr = ADDR_W'(leg_addr);
    else if (path_flat64)
      flat_addr = keeps_base64(seg) ? (base + offset) : offset;
    else
      flat_addr = ADDR_W'(cmp_addr);
  end

endmodule

// File: rtl/seg_attr_check.sv
module seg_attr_check
  import seg_xlat_pkg::*;
#(
  parameter int LIMIT_W = 32
) (
  input  logic               path_legacy,
  input  logic               path_flat64,
  input  logic               present,
  input  logic               dtype,
  input  logic [3:0]         seg_type,
  input  logic               gran,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [LIMIT_W-1:0] off_lo,
  output logic               lim_fail,
  output logic               is_expdown,
  output xlat_status_e       status
);

  localparam int SMALL_W = 16;

  logic beyond_limit;
  logic beyond_small;
  logic is_code;

  assign is_code      = seg_type[3];
  assign is_expdown   = !is_code && seg_type[2];
  assign beyond_limit = off_lo > limit;
  assign beyond_small = |off_lo[LIMIT_W-1:SMALL_W];

  always_comb begin
    if (is_expdown)
      lim_fail = !beyond_limit || (!gran && beyond_small);
    else
      lim_fail = beyond_limit;
  end

  always_comb begin
    if (path_legacy)      status = XS_OK;
    else if (!present)    status = XS_ABSENT;
    else if (!dtype)      status = XS_BADTYPE;
    else if (path_flat64) status = XS_OK;
    else if (lim_fail)    status = XS_BOUNDS;
    else                  status = XS_OK;
  end

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  xlat_status_e      status_in,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        status_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      status_q <= XS_OK;
    end else begin
      valid_q <= load;
      if (load) begin
        addr_q   <= (status_in == XS_OK) ? addr_in : '0;
        status_q <= status_in;
      end
    end
  end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic [2:0]         req_seg,
  input  logic [SEL_W-1:0]   seg_sel,
  input  logic [ADDR_W-1:0]  seg_base,
  input  logic [LIMIT_W-1:0] seg_limit,
  input  logic               seg_present,
  input  logic               seg_dtype,
  input  logic [3:0]         seg_type,
  input  logic               seg_gran,
  input  logic               seg_hid_ok,
  input  logic [ADDR_W-1:0]  req_offset,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [1:0]         rsp_status
);

  logic              path_legacy;
  logic              path_flat64;
  logic              lim_fail;
  logic              is_expdown;
  logic [ADDR_W-1:0] flat_addr;
  xlat_status_e      xlat_status;

  seg_addr_gen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_addr (
    .mode        (req_mode),
    .seg         (req_seg),
    .sel         (seg_sel),
    .base        (seg_base),
    .hid_ok      (seg_hid_ok),
    .offset      (req_offset),
    .path_legacy (path_legacy),
    .path_flat64 (path_flat64),
    .flat_addr   (flat_addr)
  );

  seg_attr_check #(.LIMIT_W(LIMIT_W)) u_attr (
    .path_legacy (path_legacy),
    .path_flat64 (path_flat64),
    .present     (seg_present),
    .dtype       (seg_dtype),
    .seg_type    (seg_type),
    .gran        (seg_gran),
    .limit       (seg_limit),
    .off_lo      (req_offset[LIMIT_W-1:0]),
    .lim_fail    (lim_fail),
    .is_expdown  (is_expdown),
    .status      (xlat_status)
  );

  seg_rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_valid),
    .addr_in   (flat_addr),
    .status_in (xlat_status),
    .valid_q   (rsp_valid),
    .addr_q    (rsp_addr),
    .status_q  (rsp_status)
  );

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int ADDR_W  = 64,
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_mode,
  input logic [2:0]         req_seg,
  input logic               seg_present,
  input logic               seg_dtype,
  input logic [LIMIT_W-1:0] seg_limit,
  input logic [ADDR_W-1:0]  req_offset,
  input logic               is_expdown,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  rsp_addr,
  input logic [1:0]         rsp_status
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_status)));

  a_r3_legacy_succeeds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1] == 1'b0) |=>
      (rsp_status == 2'd0 && rsp_addr[ADDR_W-1:32] == '0));

  a_r4_flat_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3 && seg_present && seg_dtype &&
     req_seg != 3'd4 && req_seg != 3'd5) |=>
      (rsp_status == 2'd0 && rsp_addr == $past(req_offset)));

  a_r7_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1] && !seg_present) |=> (rsp_status == 2'd3));

  a_r10_expdown_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd2 && seg_present && seg_dtype && is_expdown &&
     req_offset[LIMIT_W-1:0] <= seg_limit) |=> (rsp_status == 2'd1));

  a_r11_fail_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_addr == '0));

endmodule

bind seg_xlat_unit seg_xlat_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .LIMIT_W(LIMIT_W)) u_chk (.*);

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [2:0]  req_seg = '0;
  logic [15:0] seg_sel = '0;
  logic [63:0] seg_base = '0;
  logic [31:0] seg_limit = '0;
  logic        seg_present = 1'b0;
  logic        seg_dtype = 1'b0;
  logic [3:0]  seg_type = '0;
  logic        seg_gran = 1'b0;
  logic        seg_hid_ok = 1'b0;
  logic [63:0] req_offset = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [1:0]  rsp_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] addr;
    logic [1:0]  st;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] last_addr;
  logic [1:0]  last_st;

  always #2 clk = ~clk;

  seg_xlat_unit dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference written from the requirement text
  function automatic exp_t model(input string tag);
    exp_t e;
    logic [63:0] a;
    logic [1:0]  s;
    e.tag = tag;
    if (req_mode < 2) begin
      a = (req_offset % 64'h10000) +
          (seg_hid_ok ? (seg_base % 64'h1_0000_0000) : 64'(seg_sel) * 16);
      a = a % 64'h1_0000_0000;
      s = 0;
    end else begin
      if (req_mode == 3)
        a = (req_seg == 4 || req_seg == 5) ? seg_base + req_offset : req_offset;
      else
        a = ((seg_base % 64'h1_0000_0000) + (req_offset % 64'h1_0000_0000)) % 64'h1_0000_0000;
      s = 0;
      if (!seg_present) s = 3;
      else if (!seg_dtype) s = 2;
      else if (req_mode == 2) begin
        if (seg_type >= 8 || seg_type < 4) begin
          if (req_offset[31:0] > seg_limit) s = 1;
        end else begin
          if (req_offset[31:0] <= seg_limit) s = 1;
          if (!seg_gran && req_offset[31:0] >= 32'h10000) s = 1;
        end
      end
      if (s != 0) a = 0;
    end
    e.addr = a;
    e.st   = s;
    return e;
  endfunction

  task automatic send(input string tag, input logic [1:0] m, input logic [2:0] sg,
                      input logic [15:0] sl, input logic [63:0] b, input logic [31:0] lim,
                      input logic p, input logic dt, input logic [3:0] ty, input logic g,
                      input logic h, input logic [63:0] off);
    req_mode = m; req_seg = sg; seg_sel = sl; seg_base = b; seg_limit = lim;
    seg_present = p; seg_dtype = dt; seg_type = ty; seg_gran = g; seg_hid_ok = h;
    req_offset = off; req_valid = 1'b1;
    sb.push_back(model(tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: actual=unexpected rsp_valid expected=no response");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " status"}, 64'(rsp_status), 64'(e.st));
        check({e.tag, " addr"}, rsp_addr, e.addr);
        last_addr = rsp_addr;
        last_st   = rsp_status;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset status", 64'(rsp_status), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: paragraph base, present ignored, high offset bits ignored
    send("R3 real sel", 2'd0, 3'd3, 16'h1234, 64'hFFFF, 32'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 64'h1234_5678_ABCD_0010);
    // R3: cached base with 32-bit wrap in v86
    send("R3 v86 wrap", 2'd1, 3'd0, 16'h0, 64'hAA_FFFF_FFF0, 32'h0, 1'b1, 1'b1, 4'h3, 1'b0, 1'b1, 64'h20);
    send("R3 real selmax", 2'd0, 3'd1, 16'hFFFF, 64'h0, 32'h0, 1'b1, 1'b1, 4'hA, 1'b0, 1'b0, 64'hFFFF);
    // R4 R5: flat segments, tiny limit ignored
    send("R4 R5 flat ds", 2'd3, 3'd3, 16'h0, 64'h1000, 32'h10, 1'b1, 1'b1, 4'h2, 1'b0, 1'b1, 64'hFFFF_0000_0000_0000);
    send("R4 gs wrap", 2'd3, 3'd5, 16'h0, 64'h8000_0000_0000_0000, 32'h0, 1'b1, 1'b1, 4'h3, 1'b0, 1'b1, 64'h8000_0000_0000_0010);
    send("R4 fs base", 2'd3, 3'd4, 16'h0, 64'h0000_7F00_0000_0000, 32'h0, 1'b1, 1'b1, 4'h2, 1'b0, 1'b1, 64'h1234);
    send("R5 code no limit", 2'd3, 3'd1, 16'h0, 64'h0, 32'h0, 1'b1, 1'b1, 4'hB, 1'b0, 1'b1, 64'h1_0000_0000);
    // R6: compat wrap, upper offset ignored
    send("R6 compat wrap", 2'd2, 3'd3, 16'h0, 64'hFFFF_F000, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h3, 1'b1, 1'b1, 64'hAB_0000_2000);
    // R7 R11
    send("R7 R11 absent prot", 2'd2, 3'd3, 16'h0, 64'h100, 32'hFFFF, 1'b0, 1'b1, 4'h3, 1'b0, 1'b1, 64'h10);
    send("R7 absent long", 2'd3, 3'd4, 16'h0, 64'h100, 32'hFFFF, 1'b0, 1'b1, 4'h3, 1'b0, 1'b1, 64'h10);
    // R8
    send("R8 system desc", 2'd2, 3'd2, 16'h0, 64'h100, 32'hFFFF, 1'b1, 1'b0, 4'h9, 1'b0, 1'b1, 64'h10);
    // R9 at and past the limit
    send("R9 code at lim", 2'd2, 3'd1, 16'h0, 64'h4000, 32'h100, 1'b1, 1'b1, 4'hA, 1'b0, 1'b1, 64'h100);
    send("R9 R11 code past", 2'd2, 3'd1, 16'h0, 64'h4000, 32'h100, 1'b1, 1'b1, 4'hA, 1'b0, 1'b1, 64'h101);
    send("R9 conf past", 2'd2, 3'd1, 16'h0, 64'h4000, 32'h100, 1'b1, 1'b1, 4'hE, 1'b0, 1'b1, 64'h101);
    send("R9 data past", 2'd2, 3'd3, 16'h0, 64'h0, 32'h7FF, 1'b1, 1'b1, 4'h2, 1'b0, 1'b1, 64'h800);
    // R10 expand-down edges
    send("R10 at lim", 2'd2, 3'd2, 16'h0, 64'h10000, 32'h0FFF, 1'b1, 1'b1, 4'h6, 1'b0, 1'b1, 64'h0FFF);
    send("R10 above lim", 2'd2, 3'd2, 16'h0, 64'h10000, 32'h0FFF, 1'b1, 1'b1, 4'h6, 1'b0, 1'b1, 64'h1000);
    send("R10 top small", 2'd2, 3'd2, 16'h0, 64'h10000, 32'h0FFF, 1'b1, 1'b1, 4'h7, 1'b0, 1'b1, 64'hFFFF);
    send("R10 past 64k", 2'd2, 3'd2, 16'h0, 64'h10000, 32'h0FFF, 1'b1, 1'b1, 4'h4, 1'b0, 1'b1, 64'h10000);
    send("R10 gran 64k", 2'd2, 3'd2, 16'h0, 64'h10000, 32'h0FFF, 1'b1, 1'b1, 4'h4, 1'b1, 1'b1, 64'h10000);

    // R2: idle cycles leave the outputs alone
    repeat (2) @(negedge clk);
    check("R2 hold addr", rsp_addr, last_addr);
    check("R2 hold status", 64'(rsp_status), 64'(last_st));
    check("R1 no pulse idle", 64'(rsp_valid), 64'd0);
    check("R1 all answered", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule